// File: doc/BRIEF.md
# Four-Phase Adiabatic Dual-Rail Phase Monitor

This block watches a gate that runs from a trapezoidal four-period power clock. It observes the power-clock level, the complementary input rails and the complementary output rails. Each of these wires is carried as a 2-bit level code: `2'b00` low, `2'b01` ramp, `2'b10` high. The code `2'b11` is read as ramp. From the power-clock code alone, the block works out which period the clock is in: Idle, Evaluate, Hold or Recovery.

The block checks the signals against the four-phase rules. The input must lead its power clock by exactly one period. It must sit on a plateau and stay put while the clock ramps. The asserted output rail must follow the clock, and its partner must stay at zero.

Each cycle the block reports at most one violation kind as a one-hot code, together with the period tag. Both are registered and appear one clock after the inputs that caused them. A saturating counter per kind lets a self-checking bench read the totals at any time.

Top module: `adb_phase_monitor`

## Requirements
- R1: `viol_period_o` shows, one clock later, the period of the sampled power-clock code.
  - Low gives Idle (0) and high gives Hold (2).
  - Ramp gives Evaluate (1) when the last plateau seen was low, and Recovery (3) when it was high.
  - After reset the last plateau is taken as low.
- R2: During Evaluate, both input rails high reports contention, which is bit 2 of `viol_o`.
- R3: During Evaluate, both input rails low reports inactive, which is bit 3 of `viol_o`.
- R4: During Evaluate, an input rail at the ramp code reports early/late, which is bit 1 of `viol_o`.
- R5: A change of either input rail's code between two consecutive cycles of the same Evaluate or Recovery period reports early/late (bit 1).
- R6: Output mismatch is bit 0 of `viol_o`. It is checked in Evaluate, Hold and Recovery, and never in Idle.
  - The input decision comes from the current Evaluate cycle, or else from the last Evaluate cycle.
  - Input true-high/false-low means the true output must equal the clock code and the false output must be low.
  - The mirrored input pair has the mirrored rule.
  - Any cycle with a low power-clock code yields no violation.
- R7: After an inactive decision, both output rails must stay low through Evaluate, Hold and Recovery, or mismatch (bit 0) is reported. After a contention or ramp decision, the outputs are not checked.
- R8: `viol_o` has at most one bit set. When several kinds hit in the same cycle, the order is contention, then inactive, then early/late, then mismatch.
- R9: Each kind has a CNT_W-bit counter that steps by one for every cycle in which that kind is reported. It holds at 2^CNT_W-1.
- R10: A synchronous active-high reset does the following:
  - clears `viol_o`, the tag and all counters;
  - clears the held decision;
  - sets the last plateau to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_lvl | input | 2 | Power-clock level code |
| in_t | input | 2 | True input rail level code |
| in_f | input | 2 | Complement input rail level code |
| out_t | input | 2 | True output rail level code |
| out_f | input | 2 | Complement output rail level code |
| viol_o | output | 4 | One-hot violation {inactive, contention, early/late, mismatch} |
| viol_period_o | output | 2 | Period tag of the reported cycle |
| cnt_inact_o | output | CNT_W | Inactive count |
| cnt_cont_o | output | CNT_W | Contention count |
| cnt_eol_o | output | CNT_W | Early/late count |
| cnt_mism_o | output | CNT_W | Mismatch count |

## Verification
The assertions check on every cycle that:
- the violation code stays one-hot or zero;
- a high clock code is tagged Hold;
- a low clock code never produces a report;
- a both-high Evaluate input is flagged as contention;
- the counters neither move without a report nor leave saturation.

Several behaviours can only be shown by the bench's scenarios:
- the decision being carried from Evaluate into Hold and Recovery;
- the priority among overlapping kinds;
- mid-period input changes;
- a counter actually reaching its ceiling.

The bench sweeps every plateau and ramp combination of the input pair against correct, swapped and stuck output waveforms.

// File: rtl/adb_mon_pkg.sv
package adb_mon_pkg;

  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_RAMP = 2'b01;
  localparam logic [1:0] LV_HIGH = 2'b10;

  typedef enum logic [1:0] {
    PER_IDLE  = 2'd0,
    PER_EVAL  = 2'd1,
    PER_HOLD  = 2'd2,
    PER_RECOV = 2'd3
  } period_e;

  typedef enum logic [1:0] {
    DEC_NONE  = 2'd0,
    DEC_TRUE  = 2'd1,
    DEC_FALSE = 2'd2,
    DEC_INACT = 2'd3
  } decision_e;

  localparam int NUM_KINDS = 4;
  localparam int K_MISM    = 0;
  localparam int K_EOL     = 1;
  localparam int K_CONT    = 2;
  localparam int K_INACT   = 3;

  // the unused code 2'b11 counts as a ramp
  function automatic logic [1:0] norm_lvl(input logic [1:0] code);
    return (code == 2'b11) ? LV_RAMP : code;
  endfunction

endpackage

// File: rtl/adb_period_track.sv
module adb_period_track
  import adb_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lvl,
  output period_e    period
);

  logic last_high;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_high <= 1'b0;
    end else if (lvl == LV_HIGH) begin
      last_high <= 1'b1;
    end else if (lvl == LV_LOW) begin
      last_high <= 1'b0;
    end
  end

  always_comb begin
    unique case (lvl)
      LV_LOW:  period = PER_IDLE;
      LV_HIGH: period = PER_HOLD;
      default: period = last_high ? PER_RECOV : PER_EVAL;
    endcase
  end

endmodule

// File: rtl/adb_input_check.sv
module adb_input_check
  import adb_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  period_e    period,
  input  logic [1:0] in_t,
  input  logic [1:0] in_f,
  output logic       hit_cont,
  output logic       hit_inact,
  output logic       hit_eol,
  output decision_e  dec_now
);

  period_e    prev_p;
  logic [1:0] prev_t;
  logic [1:0] prev_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_p <= PER_IDLE;
      prev_t <= LV_LOW;
      prev_f <= LV_LOW;
    end else begin
      prev_p <= period;
      prev_t <= in_t;
      prev_f <= in_f;
    end
  end

  logic on_ramp;
  logic moved;
  logic in_eval;

  always_comb begin
    in_eval   = (period == PER_EVAL);
    on_ramp   = in_eval || (period == PER_RECOV);
    moved     = on_ramp && (prev_p == period) &&
                ((in_t != prev_t) || (in_f != prev_f));
    hit_cont  = in_eval && (in_t == LV_HIGH) && (in_f == LV_HIGH);
    hit_inact = in_eval && (in_t == LV_LOW) && (in_f == LV_LOW);
    hit_eol   = moved || (in_eval && ((in_t == LV_RAMP) || (in_f == LV_RAMP)));

    if ((in_t == LV_HIGH) && (in_f == LV_LOW)) begin
      dec_now = DEC_TRUE;
    end else if ((in_t == LV_LOW) && (in_f == LV_HIGH)) begin
      dec_now = DEC_FALSE;
    end else if ((in_t == LV_LOW) && (in_f == LV_LOW)) begin
      dec_now = DEC_INACT;
    end else begin
      dec_now = DEC_NONE;
    end
  end

endmodule

// File: rtl/adb_output_check.sv
module adb_output_check
  import adb_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  period_e    period,
  input  decision_e  dec_now,
  input  logic [1:0] pc,
  input  logic [1:0] out_t,
  input  logic [1:0] out_f,
  output logic       hit_mism
);

  decision_e dec_q;
  decision_e dec_use;

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q <= DEC_NONE;
    end else begin
      unique case (period)
        PER_IDLE: dec_q <= DEC_NONE;
        PER_EVAL: dec_q <= dec_now;
        default:  dec_q <= dec_q;
      endcase
    end
  end

  always_comb begin
    dec_use  = (period == PER_EVAL) ? dec_now : dec_q;
    hit_mism = 1'b0;
    if (period != PER_IDLE) begin
      unique case (dec_use)
        DEC_TRUE:  hit_mism = (out_t != pc) || (out_f != LV_LOW);
        DEC_FALSE: hit_mism = (out_t != LV_LOW) || (out_f != pc);
        DEC_INACT: hit_mism = (out_t != LV_LOW) || (out_f != LV_LOW);
        default:   hit_mism = 1'b0;
      endcase
    end
  end

  // R7: a held inactive decision during Hold with a raised output must be flagged
  AST_INACT_HOLD_OUT: assert property (@(posedge clk) disable iff (rst)
    (period == PER_HOLD && dec_q == DEC_INACT && out_t != LV_LOW) |-> hit_mism); // R7

endmodule

// File: rtl/adb_sat_counter.sv
module adb_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);

  localparam logic [W-1:0] CEIL = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (inc && (count != CEIL)) begin
      count <= count + 1'b1;
    end
  end

  AST_CNT_IDLE: assert property (@(posedge clk) disable iff (rst)
    !inc |=> $stable(count)); // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    (count == CEIL) |=> (count == CEIL)); // R9

endmodule

// File: rtl/adb_phase_monitor.sv
module adb_phase_monitor
  import adb_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       pc_lvl,
  input  logic [1:0]       in_t,
  input  logic [1:0]       in_f,
  input  logic [1:0]       out_t,
  input  logic [1:0]       out_f,
  output logic [3:0]       viol_o,
  output logic [1:0]       viol_period_o,
  output logic [CNT_W-1:0] cnt_inact_o,
  output logic [CNT_W-1:0] cnt_cont_o,
  output logic [CNT_W-1:0] cnt_eol_o,
  output logic [CNT_W-1:0] cnt_mism_o
);

  logic [1:0] pc_n, it_n, if_n, ot_n, of_n;

  always_comb begin
    pc_n = norm_lvl(pc_lvl);
    it_n = norm_lvl(in_t);
    if_n = norm_lvl(in_f);
    ot_n = norm_lvl(out_t);
    of_n = norm_lvl(out_f);
  end

  period_e   period;
  decision_e dec_now;
  logic      hit_cont, hit_inact, hit_eol, hit_mism;

  adb_period_track u_track (
    .clk    (clk),
    .rst    (rst),
    .lvl    (pc_n),
    .period (period)
  );

  adb_input_check u_in (
    .clk       (clk),
    .rst       (rst),
    .period    (period),
    .in_t      (it_n),
    .in_f      (if_n),
    .hit_cont  (hit_cont),
    .hit_inact (hit_inact),
    .hit_eol   (hit_eol),
    .dec_now   (dec_now)
  );

  adb_output_check u_out (
    .clk      (clk),
    .rst      (rst),
    .period   (period),
    .dec_now  (dec_now),
    .pc       (pc_n),
    .out_t    (ot_n),
    .out_f    (of_n),
    .hit_mism (hit_mism)
  );

  logic [NUM_KINDS-1:0] pick;

  always_comb begin
    pick = '0;
    if (hit_cont) begin
      pick[K_CONT] = 1'b1;
    end else if (hit_inact) begin
      pick[K_INACT] = 1'b1;
    end else if (hit_eol) begin
      pick[K_EOL] = 1'b1;
    end else if (hit_mism) begin
      pick[K_MISM] = 1'b1;
    end
  end

  logic [NUM_KINDS-1:0] viol_q;
  period_e              period_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_q   <= '0;
      period_q <= PER_IDLE;
    end else begin
      viol_q   <= pick;
      period_q <= period;
    end
  end

  logic [CNT_W-1:0] cnt [NUM_KINDS];

  for (genvar g = 0; g < NUM_KINDS; g++) begin : g_cnt
    adb_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .inc   (pick[g]),
      .count (cnt[g])
    );
  end

  assign viol_o        = viol_q;
  assign viol_period_o = period_q;
  assign cnt_inact_o   = cnt[K_INACT];
  assign cnt_cont_o    = cnt[K_CONT];
  assign cnt_eol_o     = cnt[K_EOL];
  assign cnt_mism_o    = cnt[K_MISM];

  AST_VIOL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(viol_o)); // R8
  AST_HOLD_TAG: assert property (@(posedge clk) disable iff (rst)
    (pc_lvl == LV_HIGH) |=> (viol_period_o == PER_HOLD)); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (pc_lvl == LV_LOW) |=> (viol_o == '0)); // R6
  AST_CONT_FLAG: assert property (@(posedge clk) disable iff (rst)
    (period == PER_EVAL && in_t == LV_HIGH && in_f == LV_HIGH) |=> viol_o[K_CONT]); // R2
  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (viol_o == '0 && cnt_mism_o == '0)); // R10

endmodule

// File: tb/adb_phase_monitor_test.sv
module adb_phase_monitor_test;

  localparam int CNT_W = 16;
  localparam int CEIL  = (1 << CNT_W) - 1;
  localparam logic [1:0] LO = 2'b00, RA = 2'b01, HI = 2'b10;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst;
  logic [1:0] pc_lvl, in_t, in_f, out_t, out_f;
  logic [3:0] viol_o;
  logic [1:0] viol_period_o;
  logic [CNT_W-1:0] cnt_inact_o, cnt_cont_o, cnt_eol_o, cnt_mism_o;

  adb_phase_monitor #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .pc_lvl(pc_lvl), .in_t(in_t), .in_f(in_f),
    .out_t(out_t), .out_f(out_f), .viol_o(viol_o), .viol_period_o(viol_period_o),
    .cnt_inact_o(cnt_inact_o), .cnt_cont_o(cnt_cont_o),
    .cnt_eol_o(cnt_eol_o), .cnt_mism_o(cnt_mism_o)
  );

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // bench reference state
  logic [1:0] m_pp, m_pt, m_pf;
  int m_dec;
  int bcnt [4];

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    m_pp = 2'd0; m_pt = LO; m_pf = LO; m_dec = 0;
    for (int k = 0; k < 4; k++) bcnt[k] = 0;
  endtask

  function automatic int classify(input logic [1:0] t, input logic [1:0] f);
    if (t == HI && f == LO) return 1;
    if (t == LO && f == HI) return 2;
    if (t == LO && f == LO) return 3;
    return 0;
  endfunction

  task automatic step(input logic [1:0] p, input logic [1:0] per, input logic [1:0] vt,
                      input logic [1:0] vf, input logic [1:0] vo, input logic [1:0] vof);
    int cls, dec, hits;
    bit cont, inact, ramp, chg, mism;
    logic [3:0] exp;
    string tag;
    pc_lvl = p; in_t = vt; in_f = vf; out_t = vo; out_f = vof;
    cls   = classify(vt, vf);
    cont  = (per == 1) && vt == HI && vf == HI;
    inact = (per == 1) && vt == LO && vf == LO;
    ramp  = (per == 1) && (vt == RA || vf == RA);
    chg   = (per == 1 || per == 3) && m_pp == per && (vt != m_pt || vf != m_pf);
    dec   = (per == 1) ? cls : (per == 0) ? 0 : m_dec;
    mism  = (per != 0) && ((dec == 1 && (vo != p || vof != LO)) ||
                           (dec == 2 && (vo != LO || vof != p)) ||
                           (dec == 3 && (vo != LO || vof != LO)));
    hits  = int'(cont) + int'(inact) + int'(ramp || chg) + int'(mism);
    exp = 4'b0000;
    tag = "R8 quiet";
    if (cont)              begin exp = 4'b0100; tag = "R2 contention"; end
    else if (inact)        begin exp = 4'b1000; tag = "R3 inactive"; end
    else if (ramp)         begin exp = 4'b0010; tag = "R4 ramp in eval"; end
    else if (chg)          begin exp = 4'b0010; tag = "R5 unstable input"; end
    else if (mism)         begin exp = 4'b0001; tag = (dec == 3) ? "R7 inactive output" : "R6 output mismatch"; end
    if (hits > 1) tag = "R8 priority";
    m_pp = per; m_pt = vt; m_pf = vf;
    if (per == 1) m_dec = cls; else if (per == 0) m_dec = 0;
    for (int k = 0; k < 4; k++) if (exp[k] && bcnt[k] < CEIL) bcnt[k]++;
    @(posedge clk);
    @(negedge clk);
    check(tag, int'(viol_o), int'(exp));
    check("R1 period tag", int'(viol_period_o), int'(per));
    check("R9 mismatch count", int'(cnt_mism_o), bcnt[0]);
    check("R9 early/late count", int'(cnt_eol_o), bcnt[1]);
    check("R9 contention count", int'(cnt_cont_o), bcnt[2]);
    check("R9 inactive count", int'(cnt_inact_o), bcnt[3]);
  endtask

  function automatic logic [3:0] drive(input int cls, input logic [1:0] lvl, input int mode);
    case (cls)
      1: return (mode == 0) ? {lvl, LO} : (mode == 1) ? {LO, lvl} : {HI, LO};
      2: return (mode == 0) ? {LO, lvl} : (mode == 1) ? {lvl, LO} : {LO, HI};
      3: return (mode == 2) ? {HI, LO} : {LO, LO};
      default: return {LO, LO};
    endcase
  endfunction

  task automatic trapezoid(input logic [1:0] ct, input logic [1:0] cf, input int mode);
    int cls;
    logic [3:0] o;
    logic [1:0] rt, rf;
    cls = classify(ct, cf);
    rt = (ct == HI) ? RA : LO;
    rf = (cf == HI) ? RA : LO;
    for (int i = 0; i < 2; i++) step(LO, 2'd0, rt, rf, LO, LO);
    for (int i = 0; i < 2; i++) begin o = drive(cls, RA, mode); step(RA, 2'd1, ct, cf, o[3:2], o[1:0]); end
    for (int i = 0; i < 2; i++) begin o = drive(cls, HI, mode); step(HI, 2'd2, rt, rf, o[3:2], o[1:0]); end
    for (int i = 0; i < 2; i++) begin o = drive(cls, RA, mode); step(RA, 2'd3, LO, LO, o[3:2], o[1:0]); end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    pc_lvl = LO; in_t = LO; in_f = LO; out_t = LO; out_f = LO;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R10 reset viol", int'(viol_o), 0);
    check("R10 reset tag", int'(viol_period_o), 0);
    check("R10 reset counters", int'(cnt_mism_o) + int'(cnt_eol_o) +
          int'(cnt_cont_o) + int'(cnt_inact_o), 0);
  endtask

  initial begin
    logic [1:0] lv [3];
    lv[0] = LO; lv[1] = RA; lv[2] = HI;
    rst = 1'b1;
    pc_lvl = LO; in_t = LO; in_f = LO; out_t = LO; out_f = LO;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    do_reset();

    // R2 R3 R4 R6 R7: every input pair against correct, swapped and stuck outputs
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int m = 0; m < 3; m++)
          trapezoid(lv[a], lv[b], m);

    // R5: input flips inside Evaluate, then moves inside Recovery
    step(LO, 2'd0, LO, LO, LO, LO);
    step(RA, 2'd1, HI, LO, RA, LO);
    step(RA, 2'd1, LO, HI, LO, RA);
    step(HI, 2'd2, LO, RA, LO, HI);
    step(RA, 2'd3, LO, LO, LO, RA);
    step(RA, 2'd3, RA, LO, LO, RA);

    // R8: inactive, early/late and mismatch in one cycle; inactive wins
    step(LO, 2'd0, LO, LO, LO, LO);
    step(RA, 2'd1, HI, LO, RA, LO);
    step(RA, 2'd1, LO, LO, RA, LO);
    step(HI, 2'd2, LO, LO, LO, LO);
    step(RA, 2'd3, LO, LO, LO, LO);

    // R10: mid-run reset clears counters
    do_reset();

    // R9: hold Evaluate with contention until the counter saturates
    step(LO, 2'd0, LO, LO, LO, LO);
    for (int i = 0; i < CEIL + 5; i++) step(RA, 2'd1, HI, HI, LO, LO);
    check("R9 saturated ceiling", int'(cnt_cont_o), CEIL);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule